// File: doc/BRIEF.md
# Resynchronising serial command deserializer

This block receives 12-bit command frames from a slow serial link made of a data line, a serial clock and an enable line, all of which arrive asynchronously to the fast system clock. Each line passes through a synchroniser. The block then finds the falling edges of the serial clock and shifts in one bit per falling edge, but only while enable is high. When a frame is complete, the block gives it to a downstream register controller as a one-cycle valid pulse, a register-select flag and a 10-bit payload.

A frame opens with a start bit of 1. The register-select bit comes next, then ten payload bits, most significant first. While idle, the receiver throws away zeros, so any run of twelve zeros puts it back in the idle state. This lets a host regain word alignment after noise with enable tied high. When enable falls, any partial frame is dropped and the block emits a one-cycle pulse.

For a data word (select = 0) the payload is a 2-bit channel address followed by 8 data bits. For a control word (select = 1) the payload is the mode bit, four range bits, four shutdown-inhibit bits and the software-activate bit. This block does not interpret either payload.

The FSM has two states. In ST_HUNT (idle), a 1 bit moves it to ST_SHIFT, and a 0 bit is discarded. In ST_SHIFT (collecting), each accepted bit goes into the shift register. The eleventh bit after the start bit completes the frame and returns the FSM to ST_HUNT. A falling edge of enable sends either state to ST_HUNT and clears the bit counter.

Top module: `serial_cmd_deser`

## Requirements
- R1: After reset, frame_vld_o, en_fall_o and frame_rs_o are 0 and frame_pay_o is 0.
- R2: Bits are taken on falling edges of ser_clk_i. A frame is a start bit of 1, then the select bit, then the payload bits in the order payload[9] down to payload[0].
- R3: frame_vld_o pulses high for exactly one system cycle after the twelfth falling edge of a frame. No pulse follows the eleventh edge.
- R4: While ser_en_i is low, falling edges of ser_clk_i are ignored and no frame is produced.
- R5: In the idle state, zero bits are discarded until a 1 start bit arrives.
- R6: With enable held high, twelve consecutive zero bits return the receiver to idle, whatever partial frame came before, so the following frame is decoded correctly.
- R7: A falling edge of ser_en_i aborts any partial frame, without a valid pulse, and produces exactly one cycle of en_fall_o.
- R8: A frame with select bit 1 shows frame_rs_o = 1 together with its payload.
- R9: Back-to-back frames are each decoded, one valid pulse per frame.
- R10: frame_rs_o and frame_pay_o change only in a cycle where frame_vld_o is high, and hold their value between frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the serial clock rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_data_i | input | 1 | Serial data line (asynchronous) |
| ser_clk_i | input | 1 | Serial clock line (asynchronous), bits taken on its falling edge |
| ser_en_i | input | 1 | Serial enable line (asynchronous), shifting only while high |
| frame_vld_o | output | 1 | One-cycle pulse when a frame completes |
| frame_rs_o | output | 1 | Register-select bit of the last frame (1 = control word) |
| frame_pay_o | output | 10 | Payload of the last frame, first received bit in bit 9 |
| en_fall_o | output | 1 | One-cycle pulse on each falling edge of the enable line |

## Verification
The bench sends a frame that stops one bit short and checks that it produces no pulse. A counter that is off by one would complete the frame early or late. It sends leading zeros, and a noise pattern followed by twelve zeros. A receiver that shifts zeros while idle, or that keeps stale alignment, would decode the following frame as a rotated word. It drops enable in the middle of a frame and then sends a fresh frame, so a design that keeps partial bits would splice them into the new payload. It also clocks a complete frame while enable is low, where a design that ignores the gate would produce a spurious frame.

// File: rtl/scd_pkg.sv
package scd_pkg;

    // Receiver states
    typedef enum logic [0:0] {
        ST_HUNT  = 1'b0,   // idle: discard zeros, wait for start bit
        ST_SHIFT = 1'b1    // collecting select bit and payload
    } scd_state_e;

    // Number of bits after the start bit: select bit plus payload
    function automatic int unsigned body_bits(input int unsigned pay_w);
        return pay_w + 1;
    endfunction

endpackage

// File: rtl/scd_sync.sv
module scd_sync #(
    parameter int unsigned WIDTH  = 3,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= async_i;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/scd_edge.sv
module scd_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_lvl_i,
    input  logic en_lvl_i,
    output logic bit_stb_o,
    output logic en_fall_o
);

    logic sclk_prev_q;
    logic en_prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_prev_q <= 1'b0;
            en_prev_q   <= 1'b0;
        end else begin
            sclk_prev_q <= sclk_lvl_i;
            en_prev_q   <= en_lvl_i;
        end
    end

    // A bit is accepted on a serial-clock fall while enable is high
    assign bit_stb_o = sclk_prev_q & ~sclk_lvl_i & en_lvl_i;
    assign en_fall_o = en_prev_q & ~en_lvl_i;

endmodule

// File: rtl/scd_shift_fsm.sv
module scd_shift_fsm
    import scd_pkg::*;
#(
    parameter int unsigned PAY_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_stb_i,
    input  logic             bit_val_i,
    input  logic             abort_i,
    output logic             vld_o,
    output logic             rs_o,
    output logic [PAY_W-1:0] pay_o,
    output logic             abort_o
);

    localparam int unsigned BODY_W = body_bits(PAY_W);
    localparam int unsigned CNT_W  = $clog2(BODY_W);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(BODY_W - 1);

    scd_state_e        state_q, state_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic [BODY_W-1:0] sh_q, sh_d;
    logic [BODY_W-1:0] full_word;
    logic              done;

    assign full_word = {sh_q[BODY_W-2:0], bit_val_i};
    assign done      = (state_q == ST_SHIFT) && bit_stb_i && !abort_i
                       && (cnt_q == LAST_IDX);

    // next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        sh_d    = sh_q;
        if (abort_i) begin
            state_d = ST_HUNT;
            cnt_d   = '0;
        end else if (bit_stb_i) begin
            unique case (state_q)
                ST_HUNT: begin
                    if (bit_val_i) begin
                        state_d = ST_SHIFT;
                        cnt_d   = '0;
                    end
                end
                ST_SHIFT: begin
                    sh_d = full_word;
                    if (cnt_q == LAST_IDX) begin
                        state_d = ST_HUNT;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                default: state_d = ST_HUNT;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HUNT;
            cnt_q   <= '0;
            sh_q    <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            sh_q    <= sh_d;
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_o   <= 1'b0;
            rs_o    <= 1'b0;
            pay_o   <= '0;
            abort_o <= 1'b0;
        end else begin
            vld_o   <= done;
            abort_o <= abort_i;
            if (done) begin
                rs_o  <= full_word[BODY_W-1];
                pay_o <= full_word[PAY_W-1:0];
            end
        end
    end

endmodule

// File: rtl/serial_cmd_deser.sv
module serial_cmd_deser #(
    parameter int unsigned PAY_W       = 10,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ser_data_i,
    input  logic             ser_clk_i,
    input  logic             ser_en_i,
    output logic             frame_vld_o,
    output logic             frame_rs_o,
    output logic [PAY_W-1:0] frame_pay_o,
    output logic             en_fall_o
);

    localparam int unsigned N_LINES = 3;

    logic [N_LINES-1:0] lines_s;
    logic               bit_stb;
    logic               en_fall;

    scd_sync #(
        .WIDTH  (N_LINES),
        .STAGES (SYNC_STAGES)
    ) sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({ser_en_i, ser_clk_i, ser_data_i}),
        .sync_o  (lines_s)
    );

    scd_edge edge_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .sclk_lvl_i (lines_s[1]),
        .en_lvl_i   (lines_s[2]),
        .bit_stb_o  (bit_stb),
        .en_fall_o  (en_fall)
    );

    scd_shift_fsm #(
        .PAY_W (PAY_W)
    ) fsm_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_stb_i (bit_stb),
        .bit_val_i (lines_s[0]),
        .abort_i   (en_fall),
        .vld_o     (frame_vld_o),
        .rs_o      (frame_rs_o),
        .pay_o     (frame_pay_o),
        .abort_o   (en_fall_o)
    );

endmodule

module scd_checker #(
    parameter int unsigned PAY_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             frame_vld,
    input logic             frame_rs,
    input logic [PAY_W-1:0] frame_pay,
    input logic             en_fall,
    input logic             bit_stb
);

    assert_vld_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        frame_vld |=> !frame_vld);

    assert_vld_after_bit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        frame_vld |-> $past(bit_stb));

    assert_enfall_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        en_fall |=> !en_fall);

    assert_abort_no_frame_R7: assert property (@(posedge clk) disable iff (!rst_n)
        en_fall |-> !frame_vld);

    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_vld |-> ($stable(frame_rs) && $stable(frame_pay)));

endmodule

bind serial_cmd_deser scd_checker #(.PAY_W(PAY_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .frame_vld (frame_vld_o),
    .frame_rs  (frame_rs_o),
    .frame_pay (frame_pay_o),
    .en_fall   (en_fall_o),
    .bit_stb   (bit_stb)
);

// File: tb/serial_cmd_deser_tb.sv
module serial_cmd_deser_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ser_data = 1'b0;
    logic       ser_clk = 1'b0;
    logic       ser_en = 1'b1;
    logic       frame_vld;
    logic       frame_rs;
    logic [9:0] frame_pay;
    logic       en_fall;

    int n_checks = 0;
    int n_bad    = 0;
    int n_frames = 0;
    int n_enfall = 0;
    logic       last_rs  = 1'b0;
    logic [9:0] last_pay = '0;

    always #4 clk = ~clk;   // 125 MHz

    serial_cmd_deser dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .ser_data_i  (ser_data),
        .ser_clk_i   (ser_clk),
        .ser_en_i    (ser_en),
        .frame_vld_o (frame_vld),
        .frame_rs_o  (frame_rs),
        .frame_pay_o (frame_pay),
        .en_fall_o   (en_fall)
    );

    always @(negedge clk) begin
        if (rst_n && frame_vld) begin
            n_frames++;
            last_rs  = frame_rs;
            last_pay = frame_pay;
        end
        if (rst_n && en_fall) n_enfall++;
    end

    task automatic check(input string req, input int actual, input int expected);
        n_checks++;
        if (actual != expected) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, actual, expected);
        end
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk);
        ser_data = b;
        repeat (2) @(negedge clk);
        ser_clk = 1'b1;
        repeat (8) @(negedge clk);
        ser_clk = 1'b0;
        repeat (8) @(negedge clk);
    endtask

    task automatic send_frame(input logic rs, input logic [9:0] pay);
        send_bit(1'b1);
        send_bit(rs);
        for (int i = 9; i >= 0; i--) send_bit(pay[i]);
        repeat (6) @(negedge clk);
    endtask

    task automatic t_reset;
        @(negedge clk);
        check("R1 vld", frame_vld, 0);
        check("R1 en_fall", en_fall, 0);
        check("R1 rs", frame_rs, 0);
        check("R1 pay", frame_pay, 0);
    endtask

    task automatic t_data_word;
        int f0 = n_frames;
        send_frame(1'b0, {2'b10, 8'hA5});
        check("R2 count", n_frames - f0, 1);
        check("R2 pay", last_pay, 10'h2A5);
        check("R2 rs", last_rs, 0);
    endtask

    task automatic t_control_word;
        int f0 = n_frames;
        send_frame(1'b1, 10'h1E3);
        check("R8 count", n_frames - f0, 1);
        check("R8 rs", last_rs, 1);
        check("R8 pay", last_pay, 10'h1E3);
        check("R10 hold rs", frame_rs, 1);
        check("R10 hold pay", frame_pay, 10'h1E3);
    endtask

    task automatic t_eleven_edges;
        int f0 = n_frames;
        logic [10:0] bits = {1'b1, 1'b0, 9'h0CC};
        for (int i = 10; i >= 0; i--) send_bit(bits[i]);
        repeat (6) @(negedge clk);
        check("R3 no pulse at 11", n_frames - f0, 0);
        send_bit(1'b1);
        repeat (6) @(negedge clk);
        check("R3 pulse at 12", n_frames - f0, 1);
        check("R3 pay", last_pay, 10'h199);
    endtask

    task automatic t_leading_zeros;
        int f0 = n_frames;
        for (int i = 0; i < 5; i++) send_bit(1'b0);
        send_frame(1'b0, 10'h0F0);
        check("R5 count", n_frames - f0, 1);
        check("R5 pay", last_pay, 10'h0F0);
    endtask

    task automatic t_resync;
        send_bit(1'b0);
        send_bit(1'b1);
        send_bit(1'b1);
        for (int i = 0; i < 12; i++) send_bit(1'b0);
        send_frame(1'b1, 10'h2C3);
        check("R6 rs", last_rs, 1);
        check("R6 pay", last_pay, 10'h2C3);
    endtask

    task automatic t_abort;
        int f0 = n_frames;
        int e0 = n_enfall;
        logic [5:0] part = 6'b110101;
        for (int i = 5; i >= 0; i--) send_bit(part[i]);
        @(negedge clk);
        ser_en = 1'b0;
        repeat (10) @(negedge clk);
        check("R7 enfall once", n_enfall - e0, 1);
        check("R7 no frame", n_frames - f0, 0);
        ser_en = 1'b1;
        repeat (6) @(negedge clk);
        send_frame(1'b0, 10'h155);
        check("R7 fresh count", n_frames - f0, 1);
        check("R7 fresh pay", last_pay, 10'h155);
    endtask

    task automatic t_en_low;
        int f0 = n_frames;
        @(negedge clk);
        ser_en = 1'b0;
        repeat (6) @(negedge clk);
        send_frame(1'b1, 10'h3FF);
        check("R4 ignored", n_frames - f0, 0);
        check("R4 pay kept", frame_pay, 10'h155);
        ser_en = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    task automatic t_back_to_back;
        int f0 = n_frames;
        send_frame(1'b0, 10'h001);
        check("R9 first", last_pay, 10'h001);
        send_frame(1'b1, 10'h200);
        check("R9 second", last_pay, 10'h200);
        check("R9 count", n_frames - f0, 2);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("test done: total=%0d bad=%0d", n_checks + 1, n_bad);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        t_data_word();
        t_control_word();
        t_eleven_edges();
        t_leading_zeros();
        t_resync();
        t_abort();
        t_en_low();
        t_back_to_back();
        $display("test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end

endmodule